// File: doc/BRIEF.md
# SPI Master Controller with Register Port

This block is a serial peripheral master that software drives through a small register port. One control word holds four settings: the sclk divider, the idle level of sclk, the sampling phase and the word length (1 to 16 bits). Writing the data offset queues a word in a four-entry transmit FIFO. Reading the same offset pops a received word from a four-entry receive FIFO. A status offset reports whether a word is being shifted and the fill state of both FIFOs.

Software normally sets the control word once. For each word it then writes the data offset and polls status until the busy flag clears. The engine takes words from the transmit FIFO one at a time. For each word it lowers the select line, shifts the word out most-significant bit first while it captures the slave's reply, and then raises select again. A control write made while a word is moving takes effect only from the next word.

Top module: `spi_master_ctrl`

## Requirements
- R1: After reset, ssN is 1, sclk is 0, the control offset 0x0 reads 0x7000 and the status offset 0x8 reads 0x0004.
- R2: The control word at offset 0x0 reads back what was written, except that bits 11:10 read as 0. Its fields are: divider in bits 7:0, idle sclk level in bit 8, phase in bit 9, word length minus one in bits 15:12.
- R3: While idle, sclk sits at the programmed idle level. During a word, each sclk level lasts exactly divider+1 clock cycles.
- R4: mosi carries the low N bits of the queued word, most-significant first, in all four mode combinations. With phase 0 the slave samples on the first edge of each bit; with phase 1 it samples on the second. Each word has exactly 2N sclk edges.
- R5: The master captures miso on the sampling edge of each bit. A read of offset 0x4 returns the received N-bit word zero-extended to 16 bits.
- R6: ssN falls divider+1 cycles before the first sclk edge of a word and rises divider+1 cycles after its last edge.
- R7: Status bit 0 (busy) is 1 for exactly (2N+1)(divider+1) cycles per word. That window starts when the word leaves the transmit FIFO and ends when the received word has been stored.
- R8: The transmit FIFO holds 4 words, and a data write made while it is full is dropped. Status bit 2 is 1 only when the transmit FIFO is empty.
- R9: The receive FIFO holds 4 words, and status bit 1 is 1 when it is full. A word received while it is full is discarded. A read of offset 0x4 while it is empty returns 0.
- R10: A control write made while busy is 1 does not alter the length or the timing of the word in progress. The new settings apply from the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register offset (0x0 control, 0x4 data, 0x8 status) |
| regWe | input | 1 | Write strobe, one cycle per write |
| regRe | input | 1 | Read strobe; at offset 0x4 it pops the receive FIFO |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for the current regAddr, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ssN | output | 1 | Slave select, active low |

## Verification
The transmit FIFO can receive a push from a data write on the same clock edge that the shift engine pops it to start a word. The receive FIFO can likewise be asked to accept a finished word while it is already full. The bench provokes both by writing six words on consecutive cycles behind a slow 16-bit transfer. That queues five words, drops the sixth and leaves the fifth received word with nowhere to go. A slave model at the pins checks that exactly the first five words appeared on mosi, in order. Readback of the receive FIFO then has to produce the first four replies followed by 0.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int DIV_W  = 8;
  localparam int LEN_W  = 4;
  localparam int DATA_W = 1 << LEN_W;

  // settings for one word; packing matches the control offset except bits 11:10
  typedef struct packed {
    logic [LEN_W-1:0] lenM1;
    logic             cpha;
    logic             cpol;
    logic [DIV_W-1:0] div;
  } spiCfg_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;
    logic toggle;
    logic drive;
    logic sample;
    logic finish;
  } spiStb_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    (full && !pop) |=> full);
endmodule

// File: rtl/spi_master_fsm.sv
module spi_master_fsm
  import spi_master_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    txEmpty,
  input  spiCfg_t nextCfg,
  input  spiCfg_t curCfg,
  output spiStb_t stb,
  output logic    busy
);
  localparam int EDGE_W = LEN_W + 2;

  typedef enum logic {ST_IDLE, ST_SHIFT} state_t;

  state_t            state;
  logic [DIV_W-1:0]  cnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] bitTotal, edgeLimit;
  logic              tick, lastDone, leadEdge;
  logic              unusedCfg;

  assign unusedCfg = ^{nextCfg.lenM1, nextCfg.cpha, nextCfg.cpol, curCfg.cpol};

  assign bitTotal  = EDGE_W'({1'b0, curCfg.lenM1}) + EDGE_W'(1);
  assign edgeLimit = bitTotal << 1;
  assign tick      = (state == ST_SHIFT) && (cnt == '0);
  assign lastDone  = (edgeCnt == edgeLimit);
  assign leadEdge  = ~edgeCnt[0];
  assign busy      = (state == ST_SHIFT);

  always_comb begin
    stb.load   = (state == ST_IDLE) && !txEmpty;
    stb.toggle = tick && !lastDone;
    stb.finish = tick && lastDone;
    stb.sample = stb.toggle && (curCfg.cpha ? !leadEdge : leadEdge);
    stb.drive  = stb.toggle && (curCfg.cpha ? leadEdge : !leadEdge);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      edgeCnt <= '0;
    end else if (stb.load) begin
      state   <= ST_SHIFT;
      cnt     <= nextCfg.div;
      edgeCnt <= '0;
    end else if (stb.toggle) begin
      cnt     <= curCfg.div;
      edgeCnt <= edgeCnt + 1'b1;
    end else if (stb.finish) begin
      state   <= ST_IDLE;
    end else if (state == ST_SHIFT) begin
      cnt     <= cnt - 1'b1;
    end
  end

  assert_edge_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (edgeCnt <= edgeLimit));
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> !busy);
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.load, stb.toggle, stb.finish}));
endmodule

// File: rtl/spi_master_datapath.sv
module spi_master_datapath
  import spi_master_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              ssN,
  input  spiStb_t           stb,
  input  logic              busy,
  output spiCfg_t           nextCfg,
  output spiCfg_t           curCfg,
  output logic              txEmpty
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(8);
  localparam spiCfg_t CFG_RESET = '{lenM1: LEN_W'(7), cpha: 1'b0, cpol: 1'b0, div: '0};

  spiCfg_t           ctrlReg;
  logic              wrCtrl, wrData, rdData;
  logic [DATA_W-1:0] txHead, rxHead, aligned;
  logic              txFull, rxFull, rxEmpty;
  logic [LEN_W-1:0]  alignShift;
  logic [DATA_W:0]   shiftTx;
  logic [DATA_W-1:0] shiftRx;
  logic              sclkR, ssNR;
  logic              unusedWdata;

  assign unusedWdata = ^regWdata[11:10];
  assign wrCtrl  = regWe && (regAddr == OFS_CTRL);
  assign wrData  = regWe && (regAddr == OFS_DATA);
  assign rdData  = regRe && (regAddr == OFS_DATA);
  assign nextCfg = ctrlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= CFG_RESET;
    else if (wrCtrl) ctrlReg <= '{lenM1: regWdata[15:12], cpha: regWdata[9],
                                  cpol: regWdata[8], div: regWdata[7:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curCfg <= CFG_RESET;
    else if (stb.load) curCfg <= ctrlReg;
  end

  spi_word_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .push(wrData), .pop(stb.load), .din(regWdata),
    .dout(txHead), .full(txFull), .empty(txEmpty));

  spi_word_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .push(stb.finish), .pop(rdData), .din(shiftRx),
    .dout(rxHead), .full(rxFull), .empty(rxEmpty));

  // the word is aligned so that its bit N-1 sits at the top of the shifter
  assign alignShift = LEN_W'(DATA_W - 1) - ctrlReg.lenM1;
  assign aligned    = txHead << alignShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftTx <= '0;
      shiftRx <= '0;
    end else if (stb.load) begin
      // phase 1 holds the first bit back until the first (driving) edge
      shiftTx <= ctrlReg.cpha ? {1'b0, aligned} : {aligned, 1'b0};
      shiftRx <= '0;
    end else begin
      if (stb.drive)  shiftTx <= shiftTx << 1;
      if (stb.sample) shiftRx <= {shiftRx[DATA_W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkR <= 1'b0;
      ssNR  <= 1'b1;
    end else begin
      if (stb.toggle)  sclkR <= ~sclkR;
      else if (!busy)  sclkR <= ctrlReg.cpol;
      if (stb.load)        ssNR <= 1'b0;
      else if (stb.finish) ssNR <= 1'b1;
    end
  end

  assign sclk = sclkR;
  assign ssN  = ssNR;
  assign mosi = shiftTx[DATA_W];

  always_comb begin
    regRdata = '0;
    if (regAddr == OFS_CTRL)
      regRdata = {ctrlReg.lenM1, 2'b00, ctrlReg.cpha, ctrlReg.cpol, ctrlReg.div};
    else if (regAddr == OFS_DATA)
      regRdata = rxEmpty ? '0 : rxHead;
    else if (regAddr == OFS_STAT)
      regRdata = {{(DATA_W-3){1'b0}}, txEmpty, rxFull, busy};
  end

  assert_ss_released_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> ssN);
  assert_ss_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.finish) |=> !ssN);
  assert_sclk_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.toggle) |=> $stable(sclk));
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(curCfg));
  assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txFull && !stb.load) |=> txFull);
endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl
  import spi_master_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ssN
);
  spiStb_t stb;
  spiCfg_t nextCfg, curCfg;
  logic    busy, txEmpty;

  spi_master_fsm uFsm (
    .clk(clk), .rstN(rstN), .txEmpty(txEmpty), .nextCfg(nextCfg),
    .curCfg(curCfg), .stb(stb), .busy(busy));

  spi_master_datapath #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)) uPath (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regRe(regRe),
    .regWdata(regWdata), .regRdata(regRdata), .miso(miso), .sclk(sclk),
    .mosi(mosi), .ssN(ssN), .stb(stb), .busy(busy), .nextCfg(nextCfg),
    .curCfg(curCfg), .txEmpty(txEmpty));
endmodule

// File: tb/sim_spi_master_ctrl.sv
`timescale 1ns/1ps
module sim_spi_master_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        sclk, mosi, ssN;
  logic        miso = 1'b0;

  int checks = 0, failures = 0;
  int cyc = 0, lastEvt = 0, timingErr = 0;
  bit rstDone = 0, active = 0, finished = 0;
  int expDiv = 0, expLen = 8, sOut = 0, sCnt = 0, slaveIdx = 0;
  bit expCpol = 0, expCpha = 0;
  logic [15:0] sIn, sTx;
  logic [15:0] slaveWords [32];
  logic [15:0] slaveRx [32];
  int          slaveBits [32];

  always #2 clk = ~clk;

  spi_master_ctrl u0 (.clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regRe(regRe), .regWdata(regWdata), .regRdata(regRdata), .sclk(sclk),
    .mosi(mosi), .miso(miso), .ssN(ssN));

  always @(posedge clk) cyc = cyc + 1;

  function automatic logic [15:0] lenMask(int len);
    return 16'((32'd1 << len) - 1);
  endfunction
  function automatic logic [15:0] cfgWord(int div, bit cpol, bit cpha, int len);
    return {4'(len - 1), 2'b00, cpha, cpol, 8'(div)};
  endfunction
  function automatic int busyCycles(int div, int len);
    return (2 * len + 1) * (div + 1);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // slave model at the pins
  always @(negedge ssN) if (rstDone) begin
    active = 1; sIn = '0; sCnt = 0; lastEvt = cyc;
    sTx = slaveWords[slaveIdx]; sOut = expLen - 1;
    if (!expCpha) begin miso = sTx[sOut]; sOut--; end
  end

  always @(sclk) if (active && ssN === 1'b0) begin
    bit lead;
    if (cyc - lastEvt != expDiv + 1) timingErr++;
    lastEvt = cyc;
    lead = (sclk !== expCpol);
    if (lead ^ expCpha) begin
      sIn = {sIn[14:0], mosi}; sCnt++;
    end else begin
      miso = (sOut >= 0) ? sTx[sOut] : 1'b0; sOut--;
    end
  end

  always @(posedge ssN) if (active) begin
    if (cyc - lastEvt != expDiv + 1) timingErr++;
    slaveRx[slaveIdx] = sIn; slaveBits[slaveIdx] = sCnt;
    slaveIdx++; active = 0;
  end

  task automatic regWrite(logic [3:0] a, logic [15:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1'b1;
    @(posedge clk); #1 regWe = 1'b0;
  endtask
  task automatic regRead(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); regAddr = a; regRe = (a == 4'h4); #1 d = regRdata;
    @(posedge clk); #1 regRe = 1'b0;
  endtask
  task automatic waitIdle();
    logic [15:0] s;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 20000; i++) begin
      regRead(4'h8, s);
      if (s[0] == 1'b0 && s[2] == 1'b1) break;
    end
  endtask

  task automatic setMode(int div, bit cpol, bit cpha, int len);
    expCpol = cpol; expCpha = cpha; expDiv = div; expLen = len;
    regWrite(4'h0, cfgWord(div, cpol, cpha, len));
    repeat (2) @(negedge clk);
  endtask

  task automatic runWord(int div, bit cpol, bit cpha, int len, logic [15:0] w);
    int idx;
    logic [15:0] d;
    setMode(div, cpol, cpha, len);
    idx = slaveIdx; timingErr = 0;
    regWrite(4'h4, w);
    waitIdle();
    check("R4 word count", slaveIdx, idx + 1);
    check("R4 edge-bit count", slaveBits[idx], len);
    check("R4 mosi word", slaveRx[idx], w & lenMask(len));
    check("R3/R6 timing", timingErr, 0);
    @(negedge clk); check("R3 idle level", sclk, cpol);
    regRead(4'h4, d);
    check("R5 rx word", d, slaveWords[idx] & lenMask(len));
  endtask

  initial begin
    logic [15:0] d;
    logic [15:0] fw [6];
    int idx0, bc;
    void'($urandom(32'd20240611));
    foreach (slaveWords[i]) slaveWords[i] = 16'($urandom);
    repeat (5) @(negedge clk);
    rstN = 1'b1; rstDone = 1;
    @(negedge clk);
    check("R1 ssN", ssN, 1'b1);
    check("R1 sclk", sclk, 1'b0);
    regRead(4'h0, d); check("R1 ctrl reset", d, 16'h7000);
    regRead(4'h8, d); check("R1 status reset", d, 16'h0004);

    regWrite(4'h0, 16'h2D5A); regRead(4'h0, d);
    check("R2 readback", d, 16'h215A);
    repeat (2) @(negedge clk); check("R3 idle cpol=1", sclk, 1'b1);

    // R4 R5 R3 R6: all four modes, directed lengths 1 and 16 plus random
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 3; k++) begin
        int len = (k == 0) ? 1 : (k == 1) ? 16 : int'($urandom_range(2, 15));
        runWord(int'($urandom_range(0, 3)), m[1], m[0], len, 16'($urandom));
      end
    end

    // R7: busy window length
    setMode(2, 1'b1, 1'b1, 4);
    regWrite(4'h4, 16'hA5C3);
    regAddr = 4'h8; bc = 0;
    for (int i = 0; i < 100 && regRdata[0] == 1'b0; i++) @(negedge clk);
    while (regRdata[0] == 1'b1 && bc < 1000) begin bc++; @(negedge clk); end
    check("R7 busy cycles", bc, busyCycles(2, 4));
    waitIdle(); regRead(4'h4, d);

    // R8 R9: push/pop collision, TX overflow drop, RX overflow discard
    setMode(3, 1'b0, 1'b1, 16);
    idx0 = slaveIdx; timingErr = 0;
    for (int i = 0; i < 6; i++) begin fw[i] = 16'($urandom); regWrite(4'h4, fw[i]); end
    regRead(4'h8, d); check("R8 tx not empty", d[2], 1'b0);
    waitIdle();
    check("R8 words sent", slaveIdx, idx0 + 5);
    for (int i = 0; i < 5; i++) check("R8 queued order", slaveRx[idx0 + i], fw[i]);
    check("R3/R6 timing burst", timingErr, 0);
    regRead(4'h8, d); check("R9 rx full", d[1], 1'b1);
    for (int i = 0; i < 4; i++) begin
      regRead(4'h4, d); check("R9 rx order", d, slaveWords[idx0 + i]);
    end
    regRead(4'h8, d); check("R9 rx not full", d[1], 1'b0);
    regRead(4'h4, d); check("R9 empty read", d, 16'h0000);

    // R10: control write during a word
    setMode(1, 1'b0, 1'b0, 8);
    idx0 = slaveIdx; timingErr = 0;
    regWrite(4'h4, 16'h3C96);
    repeat (6) @(negedge clk);
    regRead(4'h8, d); check("R10 busy mid-word", d[0], 1'b1);
    regWrite(4'h0, cfgWord(0, 1'b0, 1'b0, 16));
    waitIdle();
    check("R10 old length", slaveBits[idx0], 8);
    check("R10 old timing", timingErr, 0);
    check("R10 old word", slaveRx[idx0], 16'h0096);
    regRead(4'h4, d); check("R10 rx", d, slaveWords[idx0] & 16'h00FF);
    expDiv = 0; expLen = 16; timingErr = 0;
    regWrite(4'h4, 16'hBEEF);
    waitIdle();
    check("R10 new length", slaveBits[idx0 + 1], 16);
    check("R10 new timing", timingErr, 0);
    check("R10 new word", slaveRx[idx0 + 1], 16'hBEEF);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule